// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting channel of a programmable interval timer. A host programs it over a byte-wide write port. It first writes a control byte, which picks the byte access pattern, the counting mode and binary or BCD arithmetic. It then writes the initial count in one or two bytes. The channel counts on its clock, is qualified or triggered by a GATE input, and drives an OUT line whose waveform depends on the mode. The live count is available as a word and through byte reads that follow the programmed access pattern. A status byte shows the output level, a pending-count flag and the programmed fields.

Two behaviours are built. The first is an interrupt on terminal count: OUT is held low while counting and goes high at zero. The second is a one-shot that GATE can retrigger: a GATE rising edge drives OUT low for N clocks. Any other mode code behaves like the terminal-count mode. A control byte whose access field is 00 is a latch request, which is handled outside this channel, so the channel ignores it.

Top module: `pit_channel`

## Requirements
- R1: After reset, OUT is low, `count` is 0x0000, and `status` is 0x70. The status byte is laid out as {OUT, pending, access[1:0], mode[2:0], bcd}.
- R2: A control write with access field wdata[5:4] not 00 stores access=wdata[5:4], mode=wdata[3:1] and bcd=wdata[0]. If the mode is 1, OUT goes high on the next cycle; for any other mode it goes low. A control write with access 00 changes nothing.
- R3: Access 01 loads {0x00, byte}, access 10 loads {byte, 0x00}, and access 11 takes the low byte first and the high byte second. A count is only complete after its last byte.
- R4: The pending flag (status bit 6) is set by a control write or a data write. It is cleared when the count is moved into the counting element: in terminal-count mode one clock after the final byte, and in one-shot mode at the trigger.
- R5: In terminal-count mode (any mode code other than 1), the count is loaded one clock after the final byte and goes down by one on each following clock. OUT stays low until the clock on which the count reaches zero and then stays high while the counter wraps and runs on.
- R6: In terminal-count mode, GATE low holds the count.
- R7: With bcd=0 the counter is a 16-bit binary count (0x0000 steps to 0xFFFF). With bcd=1 each nibble is a decimal digit (0x0100 steps to 0x0099, and 0x0000 steps to 0x9999).
- R8: Byte reads return the low byte for access 01 and the high byte for access 10. For access 11 they alternate low, high, low and so on, starting with low after every control write.
- R9: In one-shot mode, a loaded count waits with OUT high and no counting until a GATE rising edge. That edge loads N and drives OUT low. OUT returns high N clocks later, and the count then holds at zero.
- R10: A GATE rising edge during a one-shot reloads N and restarts the low period.
- R11: Mode codes 2 to 5 produce the same count and OUT timing as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_we | input | 1 | Control byte write strobe |
| data_we | input | 1 | Count byte write strobe |
| data_rd | input | 1 | Count byte read strobe (advances the byte order) |
| wdata | input | 8 | Write data |
| gate | input | 1 | Gate / trigger input |
| out | output | 1 | Timer output |
| rdata | output | 8 | Selected byte of the live count |
| count | output | 16 | Live counting element |
| status | output | 8 | {OUT, pending, access, mode, bcd} |

## Verification
A control write takes effect on OUT and status one clock after its strobe. A finished count is loaded one clock after its last byte in terminal-count mode, so the value N-k is due 1+k clocks after that byte. In one-shot mode the count and the low OUT appear on the clock that samples the GATE rise, and OUT rises N clocks later. The bench drives all strobes on the falling edge, counts the exact number of rising edges to each of these points, and samples in the following low phase. It reads `rdata` combinationally while the read strobe is high, before the edge that moves the byte pointer.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctl_s;

  typedef enum logic [1:0] {
    CE_IDLE,
    CE_ARMED,
    CE_RUN
  } ce_st_e;

  localparam logic [MODE_W-1:0] MODE_ONESHOT = 3'd1;

  // one step down, binary or per-digit decimal with borrow
  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] v,
                                                 input logic bcd);
    logic [CNT_W-1:0] r;
    logic             borrow;
    r      = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - 1'b1;
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[d*4 +: 4] == 4'd0) begin
            r[d*4 +: 4] = 4'd9;
          end else begin
            r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
            borrow      = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_rst_sync.sv
module pit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_we,
  input  logic              data_we,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              xfer,
  output logic              cw_acc,
  output logic              cw_one_shot,
  output ctl_s              ctl,
  output logic [CNT_W-1:0]  cnt_init,
  output logic              load_pend,
  output logic              pending,
  output logic              rd_sel_hi
);
  ctl_s             ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_hi_q, wr_hi_d;
  logic             rd_hi_q, rd_hi_d;
  logic             load_q, load_d;
  logic             pend_q, pend_d;
  logic             ctl_en, cnt_en, ptr_en;

  assign cw_acc      = cw_we && (wdata[5:4] != ACC_LATCH);
  assign cw_one_shot = (wdata[3:1] == MODE_ONESHOT);

  always_comb begin
    ctl_d   = ctl_q;
    cnt_d   = cnt_q;
    wr_hi_d = wr_hi_q;
    rd_hi_d = rd_hi_q;
    load_d  = 1'b0;
    pend_d  = pend_q;
    if (xfer) pend_d = 1'b0;
    if (cw_acc) begin
      ctl_d   = ctl_s'(wdata[5:0]);
      wr_hi_d = 1'b0;
      rd_hi_d = 1'b0;
      pend_d  = 1'b1;
    end else begin
      if (data_we) begin
        pend_d = 1'b1;
        unique case (ctl_q.acc)
          ACC_LO: begin
            cnt_d  = {{BYTE_W{1'b0}}, wdata};
            load_d = 1'b1;
          end
          ACC_HI: begin
            cnt_d  = {wdata, {BYTE_W{1'b0}}};
            load_d = 1'b1;
          end
          ACC_LOHI: begin
            if (!wr_hi_q) begin
              cnt_d[BYTE_W-1:0] = wdata;
              wr_hi_d           = 1'b1;
            end else begin
              cnt_d[CNT_W-1:BYTE_W] = wdata;
              wr_hi_d               = 1'b0;
              load_d                = 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (data_rd && ctl_q.acc == ACC_LOHI) rd_hi_d = !rd_hi_q;
    end
  end

  assign ctl_en = cw_acc;
  assign cnt_en = data_we && !cw_acc;
  assign ptr_en = cw_acc || data_we || data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '{acc: ACC_LOHI, mode: '0, bcd: 1'b0};
      cnt_q   <= '0;
      wr_hi_q <= 1'b0;
      rd_hi_q <= 1'b0;
      load_q  <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (ptr_en) begin
        wr_hi_q <= wr_hi_d;
        rd_hi_q <= rd_hi_d;
      end
      load_q <= load_d;
      pend_q <= pend_d;
    end
  end

  assign ctl       = ctl_q;
  assign cnt_init  = cnt_q;
  assign load_pend = load_q;
  assign pending   = pend_q;

  always_comb begin
    unique case (ctl_q.acc)
      ACC_HI:   rd_sel_hi = 1'b1;
      ACC_LOHI: rd_sel_hi = rd_hi_q;
      default:  rd_sel_hi = 1'b0;
    endcase
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             cw_acc,
  input  logic             cw_one_shot,
  input  ctl_s             ctl,
  input  logic             load_pend,
  input  logic [CNT_W-1:0] cnt_init,
  output logic [CNT_W-1:0] ce,
  output logic             out,
  output logic             xfer
);
  logic [CNT_W-1:0] ce_q, ce_d, ce_dec;
  ce_st_e           st_q, st_d;
  logic             out_q, out_d;
  logic             gate_q, rise, one_shot, at_one;

  assign one_shot = (ctl.mode == MODE_ONESHOT);
  assign rise     = gate && !gate_q;
  assign ce_dec   = dec_count(ce_q, ctl.bcd);
  assign at_one   = (ce_q == CNT_W'(1));

  always_comb begin
    ce_d  = ce_q;
    st_d  = st_q;
    out_d = out_q;
    xfer  = 1'b0;
    if (cw_acc) begin
      st_d  = CE_IDLE;
      out_d = cw_one_shot;
    end else if (one_shot) begin
      if (load_pend && st_q == CE_IDLE) st_d = CE_ARMED;
      if (rise && (st_q != CE_IDLE || load_pend)) begin
        ce_d  = cnt_init;
        out_d = 1'b0;
        st_d  = CE_RUN;
        xfer  = 1'b1;
      end else if (st_q == CE_RUN) begin
        ce_d = ce_dec;
        if (at_one) begin
          out_d = 1'b1;
          st_d  = CE_ARMED;
        end
      end
    end else begin
      if (load_pend) begin
        ce_d  = cnt_init;
        out_d = 1'b0;
        st_d  = CE_RUN;
        xfer  = 1'b1;
      end else if (st_q == CE_RUN && gate) begin
        ce_d = ce_dec;
        if (at_one) out_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= '0;
      st_q   <= CE_IDLE;
      out_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      ce_q   <= ce_d;
      st_q   <= st_d;
      out_q  <= out_d;
      gate_q <= gate;
    end
  end

  assign ce  = ce_q;
  assign out = out_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_we,
  input  logic              data_we,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              gate,
  output logic              out,
  output logic [BYTE_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] status
);
  logic             rst_sync_n;
  logic             cw_acc, cw_one_shot, load_pend, pending, rd_sel_hi, xfer;
  ctl_s             ctl;
  logic [CNT_W-1:0] cnt_init, ce;

  pit_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  pit_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cw_we       (cw_we),
    .data_we     (data_we),
    .data_rd     (data_rd),
    .wdata       (wdata),
    .xfer        (xfer),
    .cw_acc      (cw_acc),
    .cw_one_shot (cw_one_shot),
    .ctl         (ctl),
    .cnt_init    (cnt_init),
    .load_pend   (load_pend),
    .pending     (pending),
    .rd_sel_hi   (rd_sel_hi)
  );

  pit_counter u_cnt (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .gate        (gate),
    .cw_acc      (cw_acc),
    .cw_one_shot (cw_one_shot),
    .ctl         (ctl),
    .load_pend   (load_pend),
    .cnt_init    (cnt_init),
    .ce          (ce),
    .out         (out),
    .xfer        (xfer)
  );

  assign count  = ce;
  assign rdata  = rd_sel_hi ? ce[CNT_W-1:BYTE_W] : ce[BYTE_W-1:0];
  assign status = {out, pending, ctl};
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cw_we,
  input logic [7:0]  wdata,
  input logic        out,
  input logic [7:0]  rdata,
  input logic [15:0] count,
  input logic [7:0]  status
);
  a_r4_pending_after_cw: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && wdata[5:4] != 2'b00) |=> status[6]);

  a_r2_mode0_out_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && wdata[5:4] != 2'b00 && wdata[3:1] != 3'd1) |=> !out);

  a_r9_oneshot_out_high_after_cw: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && wdata[5:4] != 2'b00 && wdata[3:1] == 3'd1) |=> out);

  a_r2_latch_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && wdata[5:4] == 2'b00) |=> $stable(status[5:0]));

  a_r5_out_rises_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out) && !$past(cw_we)) |-> (count == 16'h0000));

  a_r8_low_byte_read: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5:4] == 2'b01) |-> (rdata == count[7:0]));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .cw_we  (cw_we),
  .wdata  (wdata),
  .out    (out),
  .rdata  (rdata),
  .count  (count),
  .status (status)
);

// File: tb/test_pit_channel.sv
`timescale 1ns/1ps
module test_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n, cw_we, data_we, data_rd, gate;
  logic [7:0]  wdata, rdata, status;
  logic        out;
  logic [15:0] count;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel i_pit_channel (
    .clk(clk), .rst_n(rst_n), .cw_we(cw_we), .data_we(data_we), .data_rd(data_rd),
    .wdata(wdata), .gate(gate), .out(out), .rdata(rdata), .count(count), .status(status)
  );

  // {bcd, initial count, steps after load, expected count}
  localparam logic [40:0] VEC [6] = '{
    {1'b0, 16'h0005, 8'd3, 16'h0002},
    {1'b0, 16'h0000, 8'd1, 16'hFFFF},
    {1'b0, 16'h0100, 8'd2, 16'h00FE},
    {1'b1, 16'h0100, 8'd1, 16'h0099},
    {1'b1, 16'h0000, 8'd1, 16'h9999},
    {1'b1, 16'h1000, 8'd2, 16'h0998}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_cw(input logic [7:0] b);
    @(negedge clk); cw_we = 1'b1; wdata = b;
    @(negedge clk); cw_we = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    @(negedge clk); data_we = 1'b1; wdata = b;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd_byte(input string req, input logic [7:0] exp);
    @(negedge clk); data_rd = 1'b1;
    #1 chk(req, rdata, exp);
    @(negedge clk); data_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cw_we = 1'b0; data_we = 1'b0; data_rd = 1'b0; gate = 1'b0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 out", out, 0);
    chk("R1 count", count, 16'h0000);
    chk("R1 status", status, 8'h70);

    // R7 vector table: decrement arithmetic
    foreach (VEC[i]) begin
      gate = 1'b1;
      wr_cw(8'h30 | {7'd0, VEC[i][40]});
      wr_byte(VEC[i][31:24]);
      wr_byte(VEC[i][39:32]);
      tick(1 + int'(VEC[i][23:16]));
      chk("R7 decrement", count, VEC[i][15:0]);
    end

    // R2/R4/R5 terminal-count mode timing
    gate = 1'b1;
    wr_cw(8'h30);
    chk("R2 mode0 out low", out, 0);
    chk("R4 pending after cw", status[6], 1);
    wr_byte(8'h03);
    wr_byte(8'h00);
    chk("R4 pending before transfer", status[6], 1);
    tick(1);
    chk("R4 pending cleared", status[6], 0);
    chk("R5 loaded", count, 16'h0003);
    tick(2);
    chk("R5 count at 1", count, 16'h0001);
    chk("R5 out low before zero", out, 0);
    tick(1);
    chk("R5 count zero", count, 16'h0000);
    chk("R5 out high at zero", out, 1);
    tick(2);
    chk("R5 out stays high", out, 1);
    chk("R5 wraps", count, 16'hFFFE);

    // R6 gate low holds
    gate = 1'b0;
    wr_cw(8'h30);
    wr_byte(8'h02);
    wr_byte(8'h00);
    tick(4);
    chk("R6 held count", count, 16'h0002);
    chk("R6 out low while held", out, 0);
    gate = 1'b1;
    tick(2);
    chk("R6 resumes to zero", count, 16'h0000);
    chk("R6 out high", out, 1);

    // R2 status fields and ignored latch code
    wr_cw(8'h13);
    chk("R2 status", status, 8'hD3);
    wr_cw(8'h00);
    chk("R2 latch code ignored", status, 8'hD3);

    // R3/R8 single-byte access
    gate = 1'b0;
    wr_cw(8'h10);
    wr_byte(8'hAB);
    tick(1);
    chk("R3 low only", count, 16'h00AB);
    rd_byte("R8 low only read", 8'hAB);
    rd_byte("R8 low only read again", 8'hAB);
    wr_cw(8'h20);
    wr_byte(8'h12);
    tick(1);
    chk("R3 high only", count, 16'h1200);
    rd_byte("R8 high only read", 8'h12);

    // R3/R8 two-byte access
    wr_cw(8'h30);
    wr_byte(8'h34);
    tick(2);
    chk("R3 not loaded after one byte", count, 16'h1200);
    wr_byte(8'h12);
    tick(1);
    chk("R3 two bytes", count, 16'h1234);
    rd_byte("R8 first low", 8'h34);
    rd_byte("R8 then high", 8'h12);
    rd_byte("R8 low again", 8'h34);
    wr_cw(8'h30);
    rd_byte("R8 pointer reset by cw", 8'h34);

    // R9 one-shot
    gate = 1'b0;
    wr_cw(8'h32);
    chk("R9 out high after cw", out, 1);
    wr_byte(8'h03);
    wr_byte(8'h00);
    tick(3);
    chk("R9 waits out high", out, 1);
    chk("R9 no count before trigger", count, 16'h1234);
    chk("R4 pending until trigger", status[6], 1);
    gate = 1'b1;
    tick(1);
    chk("R9 trigger loads", count, 16'h0003);
    chk("R9 out low on trigger", out, 0);
    chk("R4 pending cleared at trigger", status[6], 0);
    tick(2);
    chk("R9 out low N-1", out, 0);
    tick(1);
    chk("R9 out high after N", out, 1);
    tick(2);
    chk("R9 holds at zero", count, 16'h0000);

    // R10 retrigger
    gate = 1'b0;
    tick(1);
    gate = 1'b1;
    tick(1);
    chk("R10 second trigger", count, 16'h0003);
    tick(1);
    gate = 1'b0;
    tick(1);
    chk("R10 mid count", count, 16'h0001);
    gate = 1'b1;
    tick(1);
    chk("R10 retrigger reload", count, 16'h0003);
    chk("R10 out low", out, 0);
    tick(3);
    chk("R10 out high after reload", out, 1);

    // R11 other mode codes
    gate = 1'b1;
    wr_cw(8'h3A);
    chk("R11 mode5 out low", out, 0);
    wr_byte(8'h02);
    wr_byte(8'h00);
    tick(2);
    chk("R11 mode5 out low", out, 0);
    tick(1);
    chk("R11 mode5 out high", out, 1);
    wr_cw(8'h34);
    wr_byte(8'h01);
    wr_byte(8'h00);
    tick(1);
    chk("R11 mode2 loaded", count, 16'h0001);
    tick(1);
    chk("R11 mode2 out high", out, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule